// File: doc/BRIEF.md
# Cross-Trigger Channel Mapping Matrix

This block routes debug events between eight trigger inputs, eight trigger outputs and four event channels. Each trigger input carries an enable mask that places its events onto channels. Each trigger output carries an enable mask that selects which channels may raise it. Software can also raise a channel directly, either as a held level or as a single-clock pulse. A raised trigger output stays high until software acknowledges it.

Local channel activity leaves the block on an outgoing channel bus through a per-channel gate. Activity on the incoming channel bus counts as channel activity for the local outputs. A clear gate bit keeps a channel inside the block, but local output mapping still works. Control and status go through a synchronous single-cycle register port: the write takes effect at the clock edge, and read data follows the address combinationally.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset, `trig_out` and `chan_out` are 0, the control word at 0x000 reads 0, and the gate word at 0x140 reads 0xF. The configuration word at 0xFC8 reads 0x00040800: the channel count is in bits [19:16] and the trigger count is in bits [15:8].
- R2: Bit 0 of 0x000 is the global enable. While it is 0, `chan_out` is 0 and trigger outputs cannot be set. Every held trigger output falls to 0 at the first clock edge at which the enable is seen as 0.
- R3: The word at 0x020+4·n is the input mask of trigger input n. If bit i is set and `trig_in[n]` is high, channel i is active in the same cycle.
- R4: The word at 0x0A0+4·n is the output mask of trigger output n. If bit i is set and channel i is active, `trig_out[n]` is 1 after the next clock edge. A high `chan_in[i]` makes channel i active.
- R5: Writing 1 to bit i at 0x014 holds channel i active. Writing 1 to bit i at 0x018 releases it. Reading 0x014 returns the held bits. Input masks have no effect on held levels.
- R6: Writing 1 to bit i at 0x01C makes channel i active for exactly one cycle, after the write edge. The bits clear themselves, so a repeated write gives a new pulse.
- R7: Trigger outputs are sticky. Writing 1 to bit n at 0x010 clears `trig_out[n]`. If a set and an acknowledge fall in the same cycle, the set wins.
- R8: Bit i at 0x140 passes local channel i activity to `chan_out[i]`. A cleared bit blocks `chan_out[i]` but does not block local trigger-output mapping. `chan_out` never reflects `chan_in`.
- R9: 0x130 reads `trig_in`, 0x134 reads `trig_out` and 0x138 reads `chan_in`. These reads return the raw levels whether or not the block is enabled. Writes to these addresses are ignored.
- R10: The write-only words (0x010, 0x018, 0x01C) and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_TRIG | Trigger input levels |
| chan_in | input | N_CHAN | Incoming channel bus |
| trig_out | output | N_TRIG | Sticky trigger outputs |
| chan_out | output | N_CHAN | Gated outgoing channel bus |
| reg_addr | input | AW | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |

## Verification
Two functions can fall in the same cycle: a channel raising a trigger output, and a software acknowledge of that same output. The bench holds an input trigger high so that its mapped outputs are set on every edge. It then writes an all-ones acknowledge, so the set and the clear meet at one edge. The outputs must still read as set afterwards, and clear only once the trigger input is released and a second acknowledge is written.

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
  parameter int N_TRIG = 8,
  parameter int N_CHAN = 4,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [N_CHAN-1:0] chan_in,
  output logic [N_TRIG-1:0] trig_out,
  output logic [N_CHAN-1:0] chan_out,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata
);
  localparam logic [AW-1:0] A_CTRL  = AW'('h000);
  localparam logic [AW-1:0] A_ACK   = AW'('h010);
  localparam logic [AW-1:0] A_HSET  = AW'('h014);
  localparam logic [AW-1:0] A_HCLR  = AW'('h018);
  localparam logic [AW-1:0] A_PULSE = AW'('h01C);
  localparam logic [AW-1:0] A_IMAP  = AW'('h020);
  localparam logic [AW-1:0] A_OMAP  = AW'('h0A0);
  localparam logic [AW-1:0] A_TIN   = AW'('h130);
  localparam logic [AW-1:0] A_TOUT  = AW'('h134);
  localparam logic [AW-1:0] A_CHIN  = AW'('h138);
  localparam logic [AW-1:0] A_GATE  = AW'('h140);
  localparam logic [AW-1:0] A_CFG   = AW'('hFC8);
  localparam logic [DW-1:0] CFG_WORD = DW'({4'(N_CHAN), 8'(N_TRIG), 8'h00});

  logic              en_q;
  logic [N_CHAN-1:0] hold_q, pulse_q, gate_q;
  logic [N_CHAN-1:0] imap_q [N_TRIG];
  logic [N_CHAN-1:0] omap_q [N_TRIG];
  logic [N_TRIG-1:0] trig_q, trig_set;
  logic [N_CHAN-1:0] trig_chan, local_act, chan_act;

  wire [N_CHAN-1:0] wd_c = reg_wdata[N_CHAN-1:0];
  wire wr_ctrl  = reg_we && reg_addr == A_CTRL;
  wire wr_ack   = reg_we && reg_addr == A_ACK;
  wire wr_hset  = reg_we && reg_addr == A_HSET;
  wire wr_hclr  = reg_we && reg_addr == A_HCLR;
  wire wr_pulse = reg_we && reg_addr == A_PULSE;
  wire wr_gate  = reg_we && reg_addr == A_GATE;

  always_comb begin
    trig_chan = '0;
    for (int n = 0; n < N_TRIG; n++)
      if (trig_in[n]) trig_chan = trig_chan | imap_q[n];
  end

  assign local_act = en_q ? (hold_q | pulse_q | trig_chan) : '0;
  assign chan_act  = local_act | (en_q ? chan_in : '0);
  assign chan_out  = local_act & gate_q;
  assign trig_out  = trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      hold_q  <= '0;
      pulse_q <= '0;
      gate_q  <= '1;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[0];
      if (wr_gate) gate_q <= wd_c;
      if (wr_hset) hold_q <= hold_q | wd_c;
      else if (wr_hclr) hold_q <= hold_q & ~wd_c;
      pulse_q <= wr_pulse ? wd_c : '0;
    end
  end

  for (genvar n = 0; n < N_TRIG; n++) begin : g_trig
    wire wr_imap = reg_we && reg_addr == A_IMAP + AW'(4 * n);
    wire wr_omap = reg_we && reg_addr == A_OMAP + AW'(4 * n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        imap_q[n] <= '0;
        omap_q[n] <= '0;
      end else begin
        if (wr_imap) imap_q[n] <= wd_c;
        if (wr_omap) omap_q[n] <= wd_c;
      end
    end

    assign trig_set[n] = |(chan_act & omap_q[n]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trig_q[n] <= 1'b0;
      else if (!en_q)      trig_q[n] <= 1'b0;
      else if (trig_set[n]) trig_q[n] <= 1'b1;
      else if (wr_ack && reg_wdata[n]) trig_q[n] <= 1'b0;
    end

    AST_MAPPED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && (|(chan_act & omap_q[n])) |=> trig_out[n]);  // R4
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: reg_rdata = DW'(en_q);
      A_HSET: reg_rdata = DW'(hold_q);
      A_TIN:  reg_rdata = DW'(trig_in);
      A_TOUT: reg_rdata = DW'(trig_q);
      A_CHIN: reg_rdata = DW'(chan_in);
      A_GATE: reg_rdata = DW'(gate_q);
      A_CFG:  reg_rdata = CFG_WORD;
      default: reg_rdata = '0;
    endcase
    for (int n = 0; n < N_TRIG; n++) begin
      if (reg_addr == A_IMAP + AW'(4 * n)) reg_rdata = DW'(imap_q[n]);
      if (reg_addr == A_OMAP + AW'(4 * n)) reg_rdata = DW'(omap_q[n]);
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> trig_out == '0);  // R2
  AST_OFF_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> chan_out == '0);  // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !wr_ack |=> ($past(trig_out) & ~trig_out) == '0);  // R7
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> pulse_q == '0);  // R6
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hset |=> (hold_q & $past(wd_c)) == $past(wd_c));  // R5
endmodule

// File: tb/test_xtrig_matrix.sv
module test_xtrig_matrix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [3:0]  chan_in = '0;
  logic [7:0]  trig_out;
  logic [3:0]  chan_out;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  xtrig_matrix i_xtrig_matrix (.*);

  // {trig_in, chan_in, expected chan_out, expected trig_out}
  localparam logic [31:0] VEC [7] = '{
    32'h01_00_01_88, 32'h20_00_02_11, 32'h00_04_00_22, 32'h0C_00_0C_66,
    32'hFF_0F_0F_FF, 32'h00_00_00_00, 32'h90_01_09_CC};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 trig_out reset", 32'(trig_out), 0);
    check("R1 chan_out reset", 32'(chan_out), 0);
    rd(12'h000, d); check("R1 control reset", d, 0);
    rd(12'h140, d); check("R1 gate reset", d, 32'hF);
    rd(12'hFC8, d); check("R1 config word", d, 32'h0004_0800);

    for (int n = 0; n < 8; n++) begin
      wr(12'h020 + 12'(4 * n), 32'(1 << (n % 4)));
      wr(12'h0A0 + 12'(4 * n), 32'(1 << ((n + 1) % 4)));
    end
    rd(12'h024, d); check("R3 input mask readback", d, 32'h2);

    trig_in = 8'hFF; chan_in = 4'hF;
    repeat (2) @(negedge clk);
    check("R2 disabled chan_out", 32'(chan_out), 0);
    check("R2 disabled trig_out", 32'(trig_out), 0);
    rd(12'h130, d); check("R9 trig_in status while off", d, 32'hFF);
    rd(12'h138, d); check("R9 chan_in status while off", d, 32'hF);
    trig_in = '0; chan_in = '0;

    wr(12'h000, 1);
    rd(12'h000, d); check("R2 control readback", d, 1);

    for (int v = 0; v < 7; v++) begin
      @(negedge clk);
      trig_in = VEC[v][31:24]; chan_in = VEC[v][19:16];
      #1 check($sformatf("R3 vector %0d chan_out", v), 32'(chan_out), 32'(VEC[v][15:8]));
      @(negedge clk);
      check($sformatf("R4 vector %0d trig_out", v), 32'(trig_out), 32'(VEC[v][7:0]));
      trig_in = '0; chan_in = '0;
      wr(12'h010, 32'hFF);
    end

    // R7 sticky and acknowledge
    @(negedge clk); trig_in = 8'h01;
    @(negedge clk); trig_in = 8'h00;
    repeat (2) @(negedge clk);
    check("R7 sticky after release", 32'(trig_out), 32'h88);
    rd(12'h134, d); check("R9 trig_out status", d, 32'h88);
    wr(12'h010, 32'h08);
    check("R7 ack clears one bit", 32'(trig_out), 32'h80);
    wr(12'h010, 32'h80);
    check("R7 ack clears rest", 32'(trig_out), 0);

    // R7 set and acknowledge in the same cycle: set wins
    trig_in = 8'h01;
    @(negedge clk);
    wr(12'h010, 32'hFF);
    check("R7 set wins over ack", 32'(trig_out), 32'h88);
    trig_in = '0;
    wr(12'h010, 32'hFF);
    check("R7 ack after release", 32'(trig_out), 0);

    // R5 held level, input masks cleared
    for (int n = 0; n < 8; n++) wr(12'h020 + 12'(4 * n), 0);
    wr(12'h014, 32'h1);
    check("R5 held level on chan_out", 32'(chan_out), 32'h1);
    rd(12'h014, d); check("R5 held readback", d, 32'h1);
    @(negedge clk);
    check("R5 held level maps to outputs", 32'(trig_out), 32'h88);
    wr(12'h018, 32'h1);
    check("R5 clear drops level", 32'(chan_out), 0);
    rd(12'h014, d); check("R5 held cleared readback", d, 0);
    wr(12'h010, 32'hFF);

    // R6 single-cycle pulse
    wr(12'h01C, 32'h2);
    check("R6 pulse visible", 32'(chan_out), 32'h2);
    rd(12'h01C, d); check("R10 pulse word reads zero", d, 0);
    @(negedge clk);
    check("R6 pulse gone after one cycle", 32'(chan_out), 0);
    check("R6 pulse sets outputs", 32'(trig_out), 32'h11);
    wr(12'h010, 32'hFF);
    wr(12'h01C, 32'h2);
    check("R6 repeated pulse", 32'(chan_out), 32'h2);
    @(negedge clk);
    wr(12'h010, 32'hFF);

    // R8 gate blocks bus only
    wr(12'h140, 0);
    wr(12'h014, 32'h1);
    check("R8 gated chan_out", 32'(chan_out), 0);
    @(negedge clk);
    check("R8 local mapping survives gate", 32'(trig_out), 32'h88);
    wr(12'h018, 32'h1);
    wr(12'h010, 32'hFF);
    wr(12'h140, 32'hF);
    chan_in = 4'h4;
    #1 check("R8 chan_in not echoed", 32'(chan_out), 0);
    @(negedge clk); chan_in = '0;
    wr(12'h010, 32'hFF);

    // R9 writes to status ignored, R10 reads of write-only and unmapped
    wr(12'h134, 32'hFF);
    rd(12'h134, d); check("R9 status write ignored", d, 0);
    check("R9 status write leaves outputs", 32'(trig_out), 0);
    rd(12'h010, d); check("R10 ack word reads zero", d, 0);
    rd(12'h018, d); check("R10 clear word reads zero", d, 0);
    rd(12'h100, d); check("R10 unmapped reads zero", d, 0);

    // R2 disabling drops held outputs
    wr(12'h014, 32'h1);
    @(negedge clk);
    wr(12'h018, 32'h1);
    check("R2 output before disable", 32'(trig_out), 32'h88);
    wr(12'h000, 0);
    @(negedge clk);
    check("R2 disable clears outputs", 32'(trig_out), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule